// File: doc/BRIEF.md
# Dual Four-Mode Timer/Counter Pair

This block holds two timer/counters of the kind found next to a small 8-bit processor core. Each timer has a low byte and a high byte, and a 2-bit mode field sets how the two bytes are combined. The four modes are a 13-bit counter, a 16-bit counter, an 8-bit counter that reloads from the high byte, and a split mode. Each timer counts one of two sources: an internal machine tick, which comes once every `CLK_DIV` core clocks, or falling edges on its own external count pin. Counting needs the timer's run bit, and can also be gated by an external level input.

Software reaches the count bytes, the mode/select byte and the control byte through a simple register port. Writes are synchronous and reads are combinational. Each timer has an overflow flag that drives an interrupt request line. A flag is cleared by a register write or by a one-cycle acknowledge strobe. Every overflow of timer 1 also appears as a one-cycle pulse on a baud-rate output.

In split mode, timer 0 becomes two separate 8-bit counters. Its high byte counts machine ticks under timer 1's run bit and raises timer 1's flag. Timer 1 itself stops while it is in split mode. While timer 0 is split, timer 1 runs whenever it is not in split mode, and it still feeds the baud output.

Top module: `dual_timer_pair`

## Requirements
- R1: The machine tick fires once in every `CLK_DIV` (12) clock cycles. A timer with select bit 0 adds exactly one per tick while it is enabled.
- R2: A timer whose run bit is 0 keeps its count. Setting the run bit does not clear the count, which then carries on from its held value.
- R3: When a timer's gate bit is 1, it counts only while its gate input is 1. When the gate bit is 0, the gate input has no effect.
- R4: Mode 0 (field value 0) counts a 13-bit value built from the high byte (upper part) and low-byte bits 4:0. Low-byte bits 7:5 never change through counting. Rolling over from 0x1FFF to 0 sets the flag.
- R5: Mode 1 (field value 1) counts all 16 bits, with the high byte as the upper part. Rolling over from 0xFFFF to 0 sets the flag.
- R6: In mode 2 (field value 2), only the low byte counts. When it overflows past 0xFF, it loads the high byte and sets the flag. The high byte is never changed by counting.
- R7: In mode 3 (field value 3), timer 0's low byte counts as an 8-bit counter under timer 0's own controls and sets flag 0. Timer 0's high byte counts machine ticks whenever run bit 1 is set, and its overflow past 0xFF sets flag 1.
- R8: Timer 1 in mode 3 holds its count, even when run bit 1 is set.
- R9: While timer 0 is in mode 3, timer 1 counts in any other mode whatever its run bit. Each of its overflows gives a one-cycle `baud_tick` pulse, but flag 1 is not set by timer 1. Moving timer 1 back into mode 3 stops it.
- R10: With select bit 1, the count pin is sampled once per machine tick. Each high-to-low change between two samples adds exactly one count, and a pin held low adds nothing more.
- R11: Writing 0 to a flag bit in the control byte clears that flag, and so does a one-cycle acknowledge. A set in the same cycle as a clear leaves the flag set, and this includes writing 1 to the flag bit.
- R12: Register map. Address 0/1 are timer 0 low/high, and 2/3 are timer 1 low/high. Address 4 is the mode byte: [1:0] mode 0, [2] select 0, [3] gate 0, [5:4] mode 1, [6] select 1, [7] gate 1. Address 5 is the control byte: [0] run 0, [1] run 1, [4] flag 0, [5] flag 1. Other addresses read 0. Everything resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| cnt_pin0 | input | 1 | External count pin, timer 0 |
| cnt_pin1 | input | 1 | External count pin, timer 1 |
| gate_in0 | input | 1 | External gate level, timer 0 |
| gate_in1 | input | 1 | External gate level, timer 1 |
| irq_ack0 | input | 1 | One-cycle acknowledge that clears flag 0 |
| irq_ack1 | input | 1 | One-cycle acknowledge that clears flag 1 |
| irq0 | output | 1 | Flag 0 (interrupt request) |
| irq1 | output | 1 | Flag 1 (interrupt request) |
| baud_tick | output | 1 | One-cycle pulse on each timer 1 overflow |

## Verification
Faults in the prescaler or the enable logic show up at the ports as a wrong count delta after a known number of machine ticks. A window of five ticks (60 clocks) is enough to tell an off-by-one from a correct count. Faults in the mode datapath, such as a wrong reload source, disturbed upper low-byte bits or a wrong byte in split mode, show up at the first overflow. They appear in the byte read back and in the flag seen in the following cycle. A wrong flag route in split mode lights the wrong `irq` line, or pulses `baud_tick`, within the same window.

// File: rtl/tmr_pair_pkg.sv
package tmr_pair_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    MODE_13     = 2'd0,
    MODE_16     = 2'd1,
    MODE_RELOAD = 2'd2,
    MODE_SPLIT  = 2'd3
  } tmode_e;

  typedef struct packed {
    logic [BYTE_W-1:0] lo;
    logic [BYTE_W-1:0] hi;
    logic              ovf;
  } step_t;

  // One count step of the main counter for a given mode.
  function automatic step_t main_step(tmode_e mode, logic [BYTE_W-1:0] lo,
                                      logic [BYTE_W-1:0] hi);
    step_t s;
    logic [BYTE_W+4:0]   v13;
    logic [2*BYTE_W-1:0] v16;
    s = '{lo: lo, hi: hi, ovf: 1'b0};
    v13 = '0;
    v16 = '0;
    case (mode)
      MODE_13: begin
        v13   = {hi, lo[4:0]} + 1'b1;
        s.ovf = &{hi, lo[4:0]};
        s.lo  = {lo[BYTE_W-1:5], v13[4:0]};
        s.hi  = v13[BYTE_W+4:5];
      end
      MODE_16: begin
        v16   = {hi, lo} + 1'b1;
        s.ovf = &{hi, lo};
        s.lo  = v16[BYTE_W-1:0];
        s.hi  = v16[2*BYTE_W-1:BYTE_W];
      end
      MODE_RELOAD: begin
        s.ovf = &lo;
        s.lo  = (&lo) ? hi : lo + 1'b1;
      end
      default: begin
        s.ovf = &lo;
        s.lo  = lo + 1'b1;
      end
    endcase
    return s;
  endfunction

endpackage

// File: rtl/tmr_tick.sv
module tmr_tick #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] pcnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          pcnt <= '0;
    else if (pcnt == LAST) pcnt <= '0;
    else                 pcnt <= pcnt + 1'b1;
  end

  assign tick = (pcnt == LAST);

  a_r1_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/tmr_edge.sv
module tmr_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pin,
  output logic evt
);
  logic pin_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    pin_q <= 1'b1;
    else if (tick) pin_q <= pin;
  end

  assign evt = tick & pin_q & ~pin;

  a_r10_one_per_tick: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> !evt);

endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pair_pkg::*;
#(
  parameter bit SPLIT_HI = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tmode_e            mode,
  input  logic              en_main,
  input  logic              en_hi,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] lo,
  output logic [BYTE_W-1:0] hi,
  output logic              ovf_main,
  output logic              ovf_hi
);
  step_t nxt;
  logic  split_hi_on;

  assign nxt         = main_step(mode, lo, hi);
  assign split_hi_on = SPLIT_HI && (mode == MODE_SPLIT) && en_hi;
  assign ovf_main    = en_main & nxt.ovf & ~wr_lo & ~wr_hi;
  assign ovf_hi      = split_hi_on & (&hi) & ~wr_hi;

  always_ff @(posedge clk) begin
    if (!rst_n)       lo <= '0;
    else if (wr_lo)   lo <= wdata;
    else if (en_main) lo <= nxt.lo;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                             hi <= '0;
    else if (wr_hi)                         hi <= wdata;
    else if (split_hi_on)                   hi <= hi + 1'b1;
    else if (en_main && mode != MODE_SPLIT) hi <= nxt.hi;
  end

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_main && !en_hi && !wr_lo && !wr_hi) |=> ($stable(lo) && $stable(hi)));

  a_r4_upper_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_13 && !wr_lo) |=> (lo[BYTE_W-1:5] == $past(lo[BYTE_W-1:5])));

  a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_RELOAD && en_main && (&lo) && !wr_lo && !wr_hi)
      |=> (lo == $past(hi) && hi == $past(hi)));

  a_r7_split_hi_step: assert property (@(posedge clk) disable iff (!rst_n)
    (split_hi_on && !wr_hi) |=> (hi == $past(hi) + 8'd1));

endmodule

// File: rtl/dual_timer_pair.sv
module dual_timer_pair
  import tmr_pair_pkg::*;
#(
  parameter int CLK_DIV = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       cnt_pin0,
  input  logic       cnt_pin1,
  input  logic       gate_in0,
  input  logic       gate_in1,
  input  logic       irq_ack0,
  input  logic       irq_ack1,
  output logic       irq0,
  output logic       irq1,
  output logic       baud_tick
);
  localparam int NT = 2;
  localparam logic [2:0] A_MODE = 3'd4;
  localparam logic [2:0] A_CTRL = 3'd5;

  logic          tick;
  logic [7:0]    mode_r;
  logic [NT-1:0] run_r;
  logic [NT-1:0] flag_r;
  logic [NT-1:0] pins, gins, acks;
  logic [NT-1:0] evt, src, qual, en_main, ovf_main, ovf_hi;
  logic [NT-1:0] wr_lo, wr_hi, flag_set, flag_clr;
  tmode_e        tmode [NT];
  logic [7:0]    lo_b [NT];
  logic [7:0]    hi_b [NT];
  logic          wr_ctrl, t0_split;

  assign pins = {cnt_pin1, cnt_pin0};
  assign gins = {gate_in1, gate_in0};
  assign acks = {irq_ack1, irq_ack0};

  assign wr_ctrl  = reg_we && reg_addr == A_CTRL;
  assign t0_split = (tmode[0] == MODE_SPLIT);

  tmr_tick #(.DIV(CLK_DIV)) u_tick (.clk(clk), .rst_n(rst_n), .tick(tick));

  for (genvar i = 0; i < NT; i++) begin : g_tmr
    logic run_eff;
    assign tmode[i] = tmode_e'(mode_r[4*i +: 2]);
    assign wr_lo[i] = reg_we && reg_addr == 3'(2*i);
    assign wr_hi[i] = reg_we && reg_addr == 3'(2*i + 1);

    tmr_edge u_edge (.clk(clk), .rst_n(rst_n), .tick(tick), .pin(pins[i]),
                     .evt(evt[i]));

    assign src[i]  = mode_r[4*i + 2] ? evt[i] : tick;
    assign qual[i] = ~mode_r[4*i + 3] | gins[i];

    if (i == 0) begin : g_t0
      assign run_eff = run_r[0];
    end else begin : g_t1
      // Timer 1: frozen in its own split mode; free-running while timer 0 is split.
      assign run_eff = (tmode[i] != MODE_SPLIT) && (t0_split || run_r[i]);
    end

    assign en_main[i] = run_eff & qual[i] & src[i];

    tmr_core #(.SPLIT_HI(i == 0)) u_core (
      .clk(clk), .rst_n(rst_n), .mode(tmode[i]),
      .en_main(en_main[i]),
      .en_hi((i == 0) ? (run_r[1] & tick) : 1'b0),
      .wr_lo(wr_lo[i]), .wr_hi(wr_hi[i]), .wdata(reg_wdata),
      .lo(lo_b[i]), .hi(hi_b[i]),
      .ovf_main(ovf_main[i]), .ovf_hi(ovf_hi[i])
    );

    assign flag_clr[i] = acks[i] | (wr_ctrl & ~reg_wdata[4 + i]);

    always_ff @(posedge clk) begin
      if (!rst_n)           flag_r[i] <= 1'b0;
      else if (flag_set[i]) flag_r[i] <= 1'b1;
      else if (flag_clr[i]) flag_r[i] <= 1'b0;
    end

    a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      flag_set[i] |=> flag_r[i]);
    a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr[i] && !flag_set[i]) |=> !flag_r[i]);
  end

  assign flag_set[0] = ovf_main[0] | (wr_ctrl & reg_wdata[4]);
  assign flag_set[1] = (t0_split ? ovf_hi[0] : ovf_main[1]) | (wr_ctrl & reg_wdata[5]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_r <= '0;
      run_r  <= '0;
    end else begin
      if (reg_we && reg_addr == A_MODE) mode_r <= reg_wdata;
      if (wr_ctrl)                      run_r  <= reg_wdata[1:0];
    end
  end

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = lo_b[0];
      3'd1:    reg_rdata = hi_b[0];
      3'd2:    reg_rdata = lo_b[1];
      3'd3:    reg_rdata = hi_b[1];
      A_MODE:  reg_rdata = mode_r;
      A_CTRL:  reg_rdata = {2'b00, flag_r, 2'b00, run_r};
      default: reg_rdata = '0;
    endcase
  end

  assign irq0      = flag_r[0];
  assign irq1      = flag_r[1];
  assign baud_tick = ovf_main[1];

  a_r8_t1_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (tmode[1] == MODE_SPLIT && !wr_lo[1] && !wr_hi[1])
      |=> ($stable(lo_b[1]) && $stable(hi_b[1])));

  a_r9_no_own_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (t0_split && !ovf_hi[0] && !flag_r[1] && !(wr_ctrl && reg_wdata[5])) |=> !flag_r[1]);

  a_r3_gate_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_r[3] && !gate_in0) |-> !en_main[0]);

endmodule

// File: tb/dual_timer_pair_tb.sv
module dual_timer_pair_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       cnt_pin0 = 1'b1, cnt_pin1 = 1'b1;
  logic       gate_in0 = 1'b0, gate_in1 = 1'b0;
  logic       irq_ack0 = 1'b0, irq_ack1 = 1'b0;
  logic       irq0, irq1, baud_tick;

  int errors = 0;
  int checks = 0;
  int baud_seen = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  dual_timer_pair u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cnt_pin0(cnt_pin0),
    .cnt_pin1(cnt_pin1), .gate_in0(gate_in0), .gate_in1(gate_in1),
    .irq_ack0(irq_ack0), .irq_ack1(irq_ack1), .irq0(irq0), .irq1(irq1),
    .baud_tick(baud_tick)
  );

  always @(negedge clk) if (rst_n && baud_tick) baud_seen++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic ticks(input int n);
    repeat (12 * n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      chk("R12 reset reg", d, 0);
    end
    chk("R12 reset irq", {irq1, irq0}, 0);
  endtask

  task automatic t_mode16();
    logic [7:0] l, h;
    wr(3'd4, 8'h01);
    wr(3'd0, 8'hFD); wr(3'd1, 8'hFF);
    wr(3'd5, 8'h01);
    ticks(5);
    rd(3'd0, l); rd(3'd1, h);
    chk("R5/R1 16-bit wrap count", {h, l}, 16'h0002);
    chk("R5 flag0 on wrap", irq0, 1);
    chk("R5 no flag1", irq1, 0);
  endtask

  task automatic t_run_hold();
    logic [7:0] l, h;
    wr(3'd5, 8'h00);
    chk("R11 write 0 clears flag0", irq0, 0);
    wr(3'd0, 8'h10); wr(3'd1, 8'h00);
    ticks(5);
    rd(3'd0, l);
    chk("R2 stopped holds", l, 8'h10);
    wr(3'd5, 8'h01);
    ticks(5);
    rd(3'd0, l); rd(3'd1, h);
    chk("R2 resume keeps count", {h, l}, 16'h0015);
    wr(3'd5, 8'h00);
  endtask

  task automatic t_gate();
    logic [7:0] l;
    wr(3'd4, 8'h09);
    wr(3'd0, 8'h20);
    gate_in0 = 1'b0;
    wr(3'd5, 8'h01);
    ticks(5);
    rd(3'd0, l);
    chk("R3 gate low blocks", l, 8'h20);
    gate_in0 = 1'b1;
    ticks(5);
    rd(3'd0, l);
    chk("R3 gate high counts", l, 8'h25);
    wr(3'd5, 8'h00);
    gate_in0 = 1'b0;
    wr(3'd4, 8'h01);
    wr(3'd5, 8'h01);
    ticks(5);
    rd(3'd0, l);
    chk("R3 gate bit 0 ignores input", l, 8'h2A);
    wr(3'd5, 8'h00);
  endtask

  task automatic t_mode13();
    logic [7:0] l, h;
    wr(3'd4, 8'h00);
    wr(3'd0, 8'hFE); wr(3'd1, 8'hFF);
    wr(3'd5, 8'h01);
    ticks(5);
    rd(3'd0, l); rd(3'd1, h);
    chk("R4 13-bit low byte keeps bits 7:5", l, 8'hE3);
    chk("R4 13-bit high byte wraps", h, 8'h00);
    chk("R4 flag0 on 13-bit wrap", irq0, 1);
    wr(3'd5, 8'h00);
  endtask

  task automatic t_reload();
    logic [7:0] l, h;
    wr(3'd4, 8'h02);
    wr(3'd0, 8'hFD); wr(3'd1, 8'hF0);
    wr(3'd5, 8'h01);
    ticks(5);
    rd(3'd0, l); rd(3'd1, h);
    chk("R6 low byte after reload", l, 8'hF2);
    chk("R6 high byte unchanged", h, 8'hF0);
    chk("R6 flag0 on reload", irq0, 1);
    wr(3'd5, 8'h00);
  endtask

  task automatic t_ext();
    logic [7:0] l, h;
    wr(3'd4, 8'h05);
    wr(3'd0, 8'h00); wr(3'd1, 8'h00);
    wr(3'd5, 8'h01);
    for (int p = 0; p < 3; p++) begin
      repeat (24) @(negedge clk);
      cnt_pin0 = 1'b0;
      repeat (36) @(negedge clk);
      cnt_pin0 = 1'b1;
    end
    repeat (24) @(negedge clk);
    rd(3'd0, l); rd(3'd1, h);
    chk("R10 three falling edges", {h, l}, 3);
    wr(3'd5, 8'h00);
  endtask

  task automatic t_split();
    logic [7:0] l, h, l1;
    wr(3'd4, 8'h33);
    wr(3'd0, 8'h10); wr(3'd1, 8'hFE);
    wr(3'd2, 8'h44);
    wr(3'd5, 8'h03);
    ticks(5);
    rd(3'd0, l); rd(3'd1, h); rd(3'd2, l1);
    chk("R7 split low byte", l, 8'h15);
    chk("R7 split high byte", h, 8'h03);
    chk("R7 high overflow sets flag1", irq1, 1);
    chk("R7 flag0 untouched", irq0, 0);
    chk("R8 timer1 frozen in mode 3", l1, 8'h44);
    wr(3'd5, 8'h00);
  endtask

  task automatic t_t1_free();
    logic [7:0] l, h;
    int b0;
    wr(3'd4, 8'h13);
    wr(3'd2, 8'hFE); wr(3'd3, 8'hFF);
    b0 = baud_seen;
    ticks(5);
    rd(3'd2, l); rd(3'd3, h);
    chk("R9 timer1 runs without run bit", {h, l}, 16'h0003);
    chk("R9 one baud pulse", baud_seen - b0, 1);
    chk("R9 no flag1 from timer1", irq1, 0);
    wr(3'd4, 8'h33);
    ticks(5);
    rd(3'd2, l);
    chk("R9 back in mode 3 stops", l, 8'h03);
  endtask

  task automatic t_ack();
    wr(3'd5, 8'h10);
    chk("R11 write 1 sets flag0", irq0, 1);
    @(negedge clk); irq_ack0 = 1'b1;
    @(negedge clk); irq_ack0 = 1'b0;
    chk("R11 ack clears flag0", irq0, 0);
    @(negedge clk);
    irq_ack0 = 1'b1; reg_we = 1'b1; reg_addr = 3'd5; reg_wdata = 8'h10;
    @(negedge clk);
    irq_ack0 = 1'b0; reg_we = 1'b0;
    chk("R11 set wins over ack", irq0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode16();
    t_run_hold();
    t_gate();
    t_mode13();
    t_reload();
    t_ext();
    t_split();
    t_t1_free();
    t_ack();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule